// File: doc/BRIEF.md
# Serial EEPROM Command Sequencer

This block sits behind a serial byte receiver in an SPI-style EEPROM. It takes whole received bytes, one strobe per byte, decodes the first byte of each chip-select frame as an instruction, and runs the flow that instruction selects. It holds an internal byte array. It also returns the next byte to be shifted out. The frame ends when the front-end reports a rising chip select. That event carries a flag telling whether the rise fell exactly between two bytes.

A read frame collects a two-byte address and then returns successive array bytes for as long as the host keeps clocking. The address wraps from the top of the array to zero. A write frame collects an address and then data bytes into a page buffer. Each buffer byte has a valid bit, and the column wraps inside a 32-byte page. The data is committed only when the frame closes cleanly. A self-timed cycle counter then copies the marked bytes into the array and holds a busy flag for a fixed number of clocks. Status reads and status writes are decoded here too. The status register itself lives in a neighbouring unit, which supplies the write-enable latch, the block-protect bits and the status byte to return.

Top module: `eeprom_cmd_seq`

## Requirements
- R1: After reset, tx_byte is 0x00 and busy, wel_set, wel_clr and sr_wr are all low.
- R2: Opcode 0x06 as the first byte of a frame pulses wel_set for one cycle, one cycle after its strobe. Opcode 0x04 pulses wel_clr the same way. Later bytes in that frame are ignored.
- R3: Any first byte other than 0x01 to 0x06 makes the block ignore every further byte until cs_rise. After such a byte, a following 0x06 gives no wel_set, and a following 0x03 leaves tx_byte at 0x00.
- R4: Opcode 0x03 takes a high then a low address byte. Only the low 12 bits of the 16-bit address are used. One cycle after the low-byte strobe, tx_byte holds the array byte at that address. Each further strobe moves to the next address, and 0xFFF is followed by 0x000.
- R5: Opcode 0x02 is accepted only when wel_in is 1 and busy is 0. Its address must also lie outside the zone selected by bp_in: 00 none, 01 addresses 0xC00 to 0xFFF, 10 addresses 0x800 to 0xFFF, 11 the whole array. A refused write changes no array byte and starts no cycle.
- R6: Write data bytes go to consecutive columns of the addressed 32-byte page, starting at the address column. After column 31 the column wraps to 0, and a later byte overwrites an earlier one.
- R7: A write is committed only when cs_rise arrives with cs_on_boundary=1 after at least one data byte. busy then rises the next cycle and stays high for exactly WR_CYCLES cycles. Only the columns that received data change.
- R8: Opcodes 0x02 and 0x03 received while busy is 1 are refused for the whole frame. tx_byte stays 0x00 and no further cycle starts.
- R9: Opcode 0x05 loads status_in into tx_byte one cycle after its strobe, and again after every further strobe of the frame. This also works while busy is 1.
- R10: Opcode 0x01 with wel_in=1 and busy=0, followed by exactly one data byte and a cs_rise with cs_on_boundary=1, pulses sr_wr one cycle later with sr_wdata equal to that byte and starts a WR_CYCLES busy period. An extra byte, a rise off the boundary, or wel_in=0 gives no sr_wr and no busy.
- R11: wel_clr pulses in the first cycle busy is low again after every self-timed cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_byte | input | 8 | Received byte |
| rx_valid | input | 1 | One-cycle strobe: rx_byte holds a complete byte |
| cs_rise | input | 1 | One-cycle strobe: chip select went inactive |
| cs_on_boundary | input | 1 | With cs_rise: the rise came exactly after a whole byte |
| wel_in | input | 1 | Write-enable latch from the status unit |
| bp_in | input | 2 | Block-protect bits from the status unit |
| status_in | input | 8 | Status byte to return on status reads |
| tx_byte | output | 8 | Next byte for the serial transmitter |
| busy | output | 1 | Self-timed write cycle in progress |
| wel_set | output | 1 | Pulse: set the write-enable latch |
| wel_clr | output | 1 | Pulse: clear the write-enable latch |
| sr_wr | output | 1 | Pulse: load sr_wdata into the status register |
| sr_wdata | output | 8 | Status byte to be written |

## Verification
A corrupted frame state shows up at tx_byte or at the pulse outputs one cycle after the next strobe. Stale read or write addresses only surface when the affected bytes are read back. A faulty page buffer or valid mask can therefore stay hidden until a later read frame. For that reason every write is followed by reads against a full model of the array. The busy window is measured cycle by cycle from the rising chip-select event, so a mistimed counter shows up as a wrong length right after the commit.

// File: rtl/eeprom_seq_pkg.sv
package eeprom_seq_pkg;
  typedef enum logic [3:0] {
    ST_OPC,    // waiting for instruction byte
    ST_AHI,    // address high byte expected
    ST_ALO,    // address low byte expected
    ST_RD,     // streaming array data
    ST_WD,     // collecting page data
    ST_RDSR,   // streaming status byte
    ST_SRD,    // status data byte expected
    ST_SREND,  // status byte taken, waiting for deselect
    ST_HOLD    // ignore bytes until deselect
  } seq_state_e;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;
endpackage

// File: rtl/esq_array.sv
module esq_array #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/esq_page_buf.sv
module esq_page_buf #(
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] wr_idx,
  input  logic [7:0]        wr_data,
  input  logic [PAGE_W-1:0] rd_idx,
  output logic [7:0]        rd_data,
  output logic              rd_vld,
  output logic              any_vld
);
  localparam int PAGE = 1 << PAGE_W;

  logic [7:0]      data_q [PAGE];
  logic [PAGE-1:0] vld_q, vld_d;

  for (genvar i = 0; i < PAGE; i++) begin : g_col
    always_ff @(posedge clk) begin
      if (wr_en && (wr_idx == PAGE_W'(i))) data_q[i] <= wr_data;
    end
  end

  always_comb begin
    vld_d = vld_q;
    if (clr)        vld_d = '0;
    else if (wr_en) vld_d[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  assign rd_data = data_q[rd_idx];
  assign rd_vld  = vld_q[rd_idx];
  assign any_vld = |vld_q;
endmodule

// File: rtl/esq_wr_timer.sv
module esq_wr_timer #(
  parameter int WR_CYCLES = 200,
  localparam int CNT_W = $clog2(WR_CYCLES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic [CNT_W-1:0] cnt,
  output logic             done
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WR_CYCLES - 1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (busy_q) begin
      if (cnt_q == LAST) begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end else if (start) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy = busy_q;
  assign cnt  = cnt_q;
  assign done = busy_q && (cnt_q == LAST);
endmodule

// File: rtl/eeprom_cmd_seq.sv
module eeprom_cmd_seq
  import eeprom_seq_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int PAGE_W    = 5,
  parameter int WR_CYCLES = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] rx_byte,
  input  logic       rx_valid,
  input  logic       cs_rise,
  input  logic       cs_on_boundary,
  input  logic       wel_in,
  input  logic [1:0] bp_in,
  input  logic [7:0] status_in,
  output logic [7:0] tx_byte,
  output logic       busy,
  output logic       wel_set,
  output logic       wel_clr,
  output logic       sr_wr,
  output logic [7:0] sr_wdata
);
  localparam int PAGE  = 1 << PAGE_W;
  localparam int CNT_W = $clog2(WR_CYCLES);
  localparam int PG_W  = ADDR_W - PAGE_W;
  localparam logic [CNT_W-1:0] PAGE_CNT = CNT_W'(PAGE);

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [PAGE_W-1:0] col_q, col_d;
  logic [PG_W-1:0]   cpage_q, cpage_d;
  logic              kind_arr_q, kind_arr_d;
  logic              is_wr_q, is_wr_d;
  logic [7:0]        tx_q, tx_d, srdat_q, srdat_d;
  logic              wset_q, wset_d, wclr_q, wclr_d, srw_q, srw_d;

  logic              tm_start, tm_busy, tm_done;
  logic [CNT_W-1:0]  tm_cnt;
  logic              buf_clr, buf_wr, buf_rd_vld, buf_any;
  logic [7:0]        buf_rd_data, arr_rdata;
  logic [ADDR_W-1:0] lo_addr, arr_raddr;
  logic              arr_we;

  // protected zone chosen by the block-protect bits
  function automatic logic in_zone(input logic [ADDR_W-1:0] a, input logic [1:0] bp);
    case (bp)
      2'b01:   in_zone = (a[ADDR_W-1 -: 2] == 2'b11);
      2'b10:   in_zone = a[ADDR_W-1];
      2'b11:   in_zone = 1'b1;
      default: in_zone = 1'b0;
    endcase
  endfunction

  assign lo_addr   = {addr_q[ADDR_W-1:8], rx_byte};
  assign arr_raddr = (state_q == ST_ALO) ? lo_addr : addr_q + ADDR_W'(1);
  assign arr_we    = tm_busy && kind_arr_q && (tm_cnt < PAGE_CNT) && buf_rd_vld;

  always_comb begin
    state_d    = state_q;
    addr_d     = addr_q;
    col_d      = col_q;
    cpage_d    = cpage_q;
    kind_arr_d = kind_arr_q;
    is_wr_d    = is_wr_q;
    tx_d       = tx_q;
    srdat_d    = srdat_q;
    wset_d     = 1'b0;
    wclr_d     = tm_done;
    srw_d      = 1'b0;
    tm_start   = 1'b0;
    buf_clr    = 1'b0;
    buf_wr     = 1'b0;
    if (cs_rise) begin
      state_d = ST_OPC;
      tx_d    = '0;
      if (state_q == ST_WD && cs_on_boundary && buf_any) begin
        tm_start   = 1'b1;
        kind_arr_d = 1'b1;
        cpage_d    = addr_q[ADDR_W-1:PAGE_W];
      end
      if (state_q == ST_SREND && cs_on_boundary) begin
        tm_start   = 1'b1;
        kind_arr_d = 1'b0;
        srw_d      = 1'b1;
      end
    end else if (rx_valid) begin
      case (state_q)
        ST_OPC: begin
          state_d = ST_HOLD;
          case (rx_byte)
            OP_WREN: wset_d = 1'b1;
            OP_WRDI: wclr_d = 1'b1;
            OP_RDSR: begin
              tx_d    = status_in;
              state_d = ST_RDSR;
            end
            OP_WRSR: if (wel_in && !tm_busy) state_d = ST_SRD;
            OP_READ: if (!tm_busy) begin
              state_d = ST_AHI;
              is_wr_d = 1'b0;
            end
            OP_WRITE: if (wel_in && !tm_busy) begin
              state_d = ST_AHI;
              is_wr_d = 1'b1;
              buf_clr = 1'b1;
            end
            default: state_d = ST_HOLD;
          endcase
        end
        ST_AHI: begin
          addr_d[ADDR_W-1:8] = rx_byte[ADDR_W-9:0];
          state_d = ST_ALO;
        end
        ST_ALO: begin
          addr_d = lo_addr;
          col_d  = lo_addr[PAGE_W-1:0];
          if (is_wr_q) begin
            state_d = in_zone(lo_addr, bp_in) ? ST_HOLD : ST_WD;
          end else begin
            tx_d    = arr_rdata;
            state_d = ST_RD;
          end
        end
        ST_RD: begin
          tx_d   = arr_rdata;
          addr_d = addr_q + ADDR_W'(1);
        end
        ST_WD: begin
          buf_wr = 1'b1;
          col_d  = col_q + PAGE_W'(1);
        end
        ST_RDSR: tx_d = status_in;
        ST_SRD: begin
          srdat_d = rx_byte;
          state_d = ST_SREND;
        end
        ST_SREND: state_d = ST_HOLD;
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_OPC;
      addr_q     <= '0;
      col_q      <= '0;
      cpage_q    <= '0;
      kind_arr_q <= 1'b0;
      is_wr_q    <= 1'b0;
      tx_q       <= '0;
      srdat_q    <= '0;
      wset_q     <= 1'b0;
      wclr_q     <= 1'b0;
      srw_q      <= 1'b0;
    end else begin
      state_q    <= state_d;
      addr_q     <= addr_d;
      col_q      <= col_d;
      cpage_q    <= cpage_d;
      kind_arr_q <= kind_arr_d;
      is_wr_q    <= is_wr_d;
      tx_q       <= tx_d;
      srdat_q    <= srdat_d;
      wset_q     <= wset_d;
      wclr_q     <= wclr_d;
      srw_q      <= srw_d;
    end
  end

  esq_array #(.ADDR_W(ADDR_W)) i_array (
    .clk   (clk),
    .we    (arr_we),
    .waddr ({cpage_q, tm_cnt[PAGE_W-1:0]}),
    .wdata (buf_rd_data),
    .raddr (arr_raddr),
    .rdata (arr_rdata)
  );

  esq_page_buf #(.PAGE_W(PAGE_W)) i_page_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (buf_clr),
    .wr_en   (buf_wr),
    .wr_idx  (col_q),
    .wr_data (rx_byte),
    .rd_idx  (tm_cnt[PAGE_W-1:0]),
    .rd_data (buf_rd_data),
    .rd_vld  (buf_rd_vld),
    .any_vld (buf_any)
  );

  esq_wr_timer #(.WR_CYCLES(WR_CYCLES)) i_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (tm_start),
    .busy  (tm_busy),
    .cnt   (tm_cnt),
    .done  (tm_done)
  );

  assign tx_byte  = tx_q;
  assign busy     = tm_busy;
  assign wel_set  = wset_q;
  assign wel_clr  = wclr_q;
  assign sr_wr    = srw_q;
  assign sr_wdata = srdat_q;
endmodule

// File: rtl/esq_checker.sv
module esq_checker #(
  parameter int WR_CYCLES = 200
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] rx_byte,
  input logic       rx_valid,
  input logic       cs_rise,
  input logic       cs_on_boundary,
  input logic [7:0] tx_byte,
  input logic       busy,
  input logic       wel_set,
  input logic       wel_clr,
  input logic       sr_wr
);
  logic [31:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_q <= '0;
    else if (busy) run_q <= run_q + 32'd1;
    else           run_q <= '0;
  end

  assert_busy_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_rise && cs_on_boundary));

  assert_busy_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_q == 32'(WR_CYCLES)));

  assert_wel_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wel_set |-> $past(rx_valid && rx_byte == 8'h06));

  assert_sr_wr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sr_wr |-> ($past(cs_rise && cs_on_boundary) && busy));

  assert_clr_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> wel_clr);

  assert_tx_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tx_byte) |-> $past(rx_valid || cs_rise));
endmodule

bind eeprom_cmd_seq esq_checker #(.WR_CYCLES(WR_CYCLES)) i_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .rx_byte        (rx_byte),
  .rx_valid       (rx_valid),
  .cs_rise        (cs_rise),
  .cs_on_boundary (cs_on_boundary),
  .tx_byte        (tx_byte),
  .busy           (busy),
  .wel_set        (wel_set),
  .wel_clr        (wel_clr),
  .sr_wr          (sr_wr)
);

// File: tb/test_eeprom_cmd_seq.sv
module test_eeprom_cmd_seq;
  localparam int DEPTH = 4096;
  localparam int WRC   = 200;

  logic       clk, rst_n;
  logic [7:0] rx_byte, status_in, tx_byte, sr_wdata;
  logic       rx_valid, cs_rise, cs_on_boundary, wel_in;
  logic [1:0] bp_in;
  logic       busy, wel_set, wel_clr, sr_wr;

  logic [7:0] model [DEPTH];
  int n_chk, n_bad;
  bit finished;

  eeprom_cmd_seq i_eeprom_cmd_seq (
    .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .cs_rise(cs_rise), .cs_on_boundary(cs_on_boundary), .wel_in(wel_in),
    .bp_in(bp_in), .status_in(status_in), .tx_byte(tx_byte), .busy(busy),
    .wel_set(wel_set), .wel_clr(wel_clr), .sr_wr(sr_wr), .sr_wdata(sr_wdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit zone(input int a, input logic [1:0] bp);
    case (bp)
      2'b01:   return ((a >> 10) & 3) == 3;
      2'b10:   return ((a >> 11) & 1) == 1;
      2'b11:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic strobe(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic cs_up(input bit bnd);
    @(negedge clk); cs_rise = 1'b1; cs_on_boundary = bnd;
    @(negedge clk); cs_rise = 1'b0; cs_on_boundary = 1'b0;
  endtask

  task automatic wait_busy(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  task automatic send_addr(input int a);
    logic [7:0] hb;
    hb = 8'($urandom);
    hb[3:0] = 4'(a >> 8);
    strobe(hb);
    strobe(8'(a));
  endtask

  task automatic do_write(input int a, input int n, input bit bnd, input bit wel,
                          input logic [1:0] bp);
    logic [7:0] dat [64];
    int cnt;
    bit acc;
    wel_in = wel; bp_in = bp;
    strobe(8'h02);
    send_addr(a);
    for (int k = 0; k < n; k++) begin
      dat[k] = 8'($urandom);
      strobe(dat[k]);
    end
    acc = wel && !zone(a, bp) && bnd && (n > 0);
    cs_up(bnd);
    chk("R7 busy after deselect", {31'd0, busy}, {31'd0, acc});
    if (acc) begin
      wait_busy(cnt);
      chk("R7 busy length", cnt, WRC);
      chk("R11 wel_clr at end", {31'd0, wel_clr}, 32'd1);
      for (int k = 0; k < n; k++)
        model[(a & ~31) | ((a + k) & 31)] = dat[k];
    end else begin
      repeat (2) @(negedge clk);
      chk("R5 refused write no busy", {31'd0, busy}, 32'd0);
    end
    wel_in = 1'b1; bp_in = 2'b00;
  endtask

  task automatic do_read(input int a, input int n, input string req);
    strobe(8'h03);
    send_addr(a);
    chk(req, tx_byte, model[a % DEPTH]);
    for (int k = 1; k < n; k++) begin
      strobe(8'($urandom));
      chk(req, tx_byte, model[(a + k) % DEPTH]);
    end
    cs_up(1'b1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int seed, cnt;
    seed = int'($urandom(32'd1357));
    n_chk = 0; n_bad = 0; finished = 1'b0;
    rst_n = 1'b0; rx_valid = 1'b0; rx_byte = '0; cs_rise = 1'b0; cs_on_boundary = 1'b0;
    wel_in = 1'b1; bp_in = 2'b00; status_in = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 tx", tx_byte, 8'h00);
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 pulses", {29'd0, wel_set, wel_clr, sr_wr}, 32'd0);

    // fill the whole array through full-page writes
    for (int p = 0; p < DEPTH / 32; p++) do_write(p * 32, 32, 1'b1, 1'b1, 2'b00);

    // R2 latch pulses
    strobe(8'h06); chk("R2 wel_set", {31'd0, wel_set}, 32'd1);
    strobe(8'h06); chk("R2 later byte ignored", {31'd0, wel_set}, 32'd0);
    cs_up(1'b1);
    strobe(8'h04); chk("R2 wel_clr", {31'd0, wel_clr}, 32'd1);
    cs_up(1'b1);

    // R3 unknown opcode
    strobe(8'h55); strobe(8'h06); chk("R3 no wel_set", {31'd0, wel_set}, 32'd0);
    strobe(8'h03); strobe(8'h00); strobe(8'h10); chk("R3 tx idle", tx_byte, 8'h00);
    cs_up(1'b1);

    // R4 read with wrap from top to zero
    do_read(DEPTH - 2, 5, "R4 read wrap");
    do_read(1234, 4, "R4 read stream");

    // R6 page wrap: 40 bytes from column 28
    do_write(5 * 32 + 28, 40, 1'b1, 1'b1, 2'b00);
    do_read(5 * 32, 32, "R6 page wrap readback");

    // R7 partial write only touches sent columns; off-boundary rise discards
    do_write(9 * 32 + 3, 2, 1'b1, 1'b1, 2'b00);
    do_read(9 * 32, 32, "R7 mask readback");
    do_write(10 * 32, 4, 1'b0, 1'b1, 2'b00);
    do_read(10 * 32, 8, "R7 no boundary unchanged");

    // R5 refusals and zones
    do_write(64, 3, 1'b1, 1'b0, 2'b00);
    do_write(12'hC10, 3, 1'b1, 1'b1, 2'b01);
    do_write(12'h100, 3, 1'b1, 1'b1, 2'b01);
    do_write(12'h900, 3, 1'b1, 1'b1, 2'b10);
    do_write(12'h020, 3, 1'b1, 1'b1, 2'b11);
    do_read(12'hC10, 3, "R5 protected unchanged");
    do_read(12'h100, 3, "R5 allowed written");
    do_read(12'h900, 3, "R5 half zone unchanged");
    do_read(64, 3, "R5 no wel unchanged");

    // R8/R9 activity during a busy cycle
    strobe(8'h02); send_addr(12'h300); strobe(8'h77); cs_up(1'b1);
    model[12'h300] = 8'h77;
    chk("R7 busy started", {31'd0, busy}, 32'd1);
    status_in = 8'hA5; strobe(8'h05); chk("R9 status during busy", tx_byte, 8'hA5);
    status_in = 8'h3C; strobe(8'h00); chk("R9 status repeat", tx_byte, 8'h3C);
    cs_up(1'b1);
    strobe(8'h03); send_addr(12'h300); chk("R8 read refused", tx_byte, 8'h00);
    strobe(8'h00); chk("R8 read refused stream", tx_byte, 8'h00);
    cs_up(1'b1);
    strobe(8'h02); send_addr(12'h301); strobe(8'hEE); cs_up(1'b1);
    wait_busy(cnt);
    chk("R11 wel_clr after cycle", {31'd0, wel_clr}, 32'd1);
    repeat (3) @(negedge clk);
    chk("R8 no second cycle", {31'd0, busy}, 32'd0);
    do_read(12'h300, 2, "R8 refused write unchanged");

    // R10 status register write
    strobe(8'h01); strobe(8'h8C); cs_up(1'b1);
    chk("R10 sr_wr", {31'd0, sr_wr}, 32'd1);
    chk("R10 sr_wdata", sr_wdata, 8'h8C);
    wait_busy(cnt);
    chk("R10 busy length", cnt, WRC);
    chk("R11 wel_clr after status", {31'd0, wel_clr}, 32'd1);
    strobe(8'h01); strobe(8'h11); strobe(8'h22); cs_up(1'b1);
    chk("R10 extra byte no sr_wr", {30'd0, sr_wr, busy}, 32'd0);
    strobe(8'h01); strobe(8'h11); cs_up(1'b0);
    chk("R10 off boundary no sr_wr", {30'd0, sr_wr, busy}, 32'd0);
    wel_in = 1'b0; strobe(8'h01); strobe(8'h11); cs_up(1'b1); wel_in = 1'b1;
    chk("R10 no wel no sr_wr", {30'd0, sr_wr, busy}, 32'd0);

    // random mix
    for (int it = 0; it < 40; it++) begin
      do_write(int'($urandom_range(DEPTH - 1)), int'($urandom_range(40, 1)),
               ($urandom_range(9) != 0), ($urandom_range(9) != 0), 2'($urandom));
      do_read(int'($urandom_range(DEPTH - 1)), int'($urandom_range(8, 1)), "R6 random readback");
    end
    for (int p = 0; p < 4; p++) do_read(p * 1024 + 512, 16, "R4 sweep readback");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule